// File: doc/BRIEF.md
# Audio Operating Mode Controller

This block holds the power and processing mode of a two-microphone audio processor. It tracks four modes: active (the noise reduction path runs), bypass (inputs go straight to the outputs with no processing), sleep (all analog circuitry off, the core clocked from the internal low-speed oscillator) and standby (a short waiting room on the way out of sleep). It drives the enables that the processing path, the statistics collector, the analog front end and the clock multiplexer need for the current mode.

Decoded commands come from a serial control interface: a mode switch carrying a target code, and a sleep request. Leaving sleep is only possible through activity on the serial clock line, and that wake lands in standby, where a mode switch must arrive before a programmable cycle count runs out, or the block drops back into sleep. A clock monitor counts internal-oscillator cycles between external clock edges and forces sleep when the programmed window passes with no edge.

Top module: `audio_mode_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after its release, the mode is bypass when `boot_bypass` is 1 and active when it is 0.
- R2: In active, bypass or standby, a valid switch with code 0 moves the mode to active and code 1 to bypass on the next clock edge.
- R3: A valid switch carrying any code other than 0 or 1 (with the default 3-bit code width, codes 2 to 7) is ignored and the mode stays unchanged.
- R4: In active, bypass or standby, a sleep request moves the mode to sleep on the next edge, and takes priority over a switch presented in the same cycle.
- R5: In sleep, switch commands and sleep requests are ignored; a cycle with `scl_act` high moves the mode to standby on the next edge.
- R6: With the standby limit at L, a standby entered with no later command returns to sleep on the (L+1)th edge after entry; a valid switch presented on that same edge wins and is taken instead.
- R7: When `ext_tick` stays low for `clk_win` consecutive edges, the clock counts as missing, and any mode other than sleep moves to sleep on the next edge, overriding every command; one tick clears the condition.
- R8: `mode_o` encodes active 0, bypass 1, sleep 2, standby 3; the enables {`proc_en_o`,`byp_sel_o`,`stats_en_o`,`analog_en_o`,`osc_int_o`} are 10110 in active, 01110 in bypass, 00001 in sleep and 00010 in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| boot_bypass | input | 1 | Boot-time choice: 1 selects bypass, 0 active |
| sw_valid | input | 1 | Decoded mode-switch command strobe |
| sw_code | input | CODE_W | Target code of the switch command |
| sleep_req | input | 1 | Decoded sleep command strobe |
| scl_act | input | 1 | Activity seen on the serial clock line |
| ext_tick | input | 1 | One pulse per external clock edge, already synchronised |
| stby_lim | input | STBY_W | Standby wait length in cycles |
| clk_win | input | WIN_W | Clock-loss window in cycles, must be nonzero |
| mode_o | output | 2 | Current mode |
| proc_en_o | output | 1 | Processing path enable |
| byp_sel_o | output | 1 | Direct input-to-output routing select |
| stats_en_o | output | 1 | Input statistics collection enable |
| analog_en_o | output | 1 | Analog block enable |
| osc_int_o | output | 1 | 1 selects the internal low-speed oscillator |

## Verification
The bench builds the block with its default parameters: a 16-bit standby counter, an 8-bit clock window, a 3-bit command code and unregistered outputs. It drives the standby limit at 5 and the clock window at 6 through the ports, which brings the timeout edge, the window boundary and their collisions with commands within a few tens of cycles. The 3-bit code width gives six undefined target codes to feed the ignore path, and cutting the tick stream exercises clock loss from active, from standby and while waking.

// File: rtl/amc_pkg.sv
`timescale 1ns/1ps
package amc_pkg;

   typedef enum logic [1:0] {
      MD_ACTIVE  = 2'd0,
      MD_BYPASS  = 2'd1,
      MD_SLEEP   = 2'd2,
      MD_STANDBY = 2'd3
   } amc_mode_e;

   typedef struct packed {
      logic proc_en;
      logic byp_sel;
      logic stats_en;
      logic analog_en;
      logic osc_int;
   } amc_ctl_t;

   function automatic amc_ctl_t amc_decode(input amc_mode_e m);
      amc_ctl_t c;
      c = '0;
      unique case (m)
         MD_ACTIVE:  begin c.proc_en = 1'b1; c.stats_en = 1'b1; c.analog_en = 1'b1; end
         MD_BYPASS:  begin c.byp_sel = 1'b1; c.stats_en = 1'b1; c.analog_en = 1'b1; end
         MD_SLEEP:   begin c.osc_int = 1'b1; end
         MD_STANDBY: begin c.analog_en = 1'b1; end
         default:    c = '0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/amc_clk_mon.sv
`timescale 1ns/1ps
module amc_clk_mon #(
   parameter int unsigned WIN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_tick,
   input  logic [WIN_W-1:0] win,
   output logic             lost
);
   localparam logic [WIN_W-1:0] SAT = '1;

   logic [WIN_W-1:0] gap_q;

   // cycles since the last external edge, held at the top value
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              gap_q <= '0;
      else if (ext_tick)       gap_q <= '0;
      else if (gap_q != SAT)   gap_q <= gap_q + 1'b1;
   end

   assign lost = (gap_q >= win);
endmodule

// File: rtl/amc_stby_timer.sv
`timescale 1ns/1ps
module amc_stby_timer #(
   parameter int unsigned STBY_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [STBY_W-1:0] limit,
   output logic              expire
);
   logic [STBY_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (!run)            cnt_q <= '0;
      else if (cnt_q != limit)  cnt_q <= cnt_q + 1'b1;
   end

   assign expire = run && (cnt_q == limit);
endmodule

// File: rtl/amc_mode_fsm.sv
`timescale 1ns/1ps
module amc_mode_fsm
   import amc_pkg::*;
#(
   parameter int unsigned CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boot_bypass,
   input  logic              sw_valid,
   input  logic [CODE_W-1:0] sw_code,
   input  logic              sleep_req,
   input  logic              scl_act,
   input  logic              clk_lost,
   input  logic              stby_exp,
   output amc_mode_e         mode_q
);
   localparam logic [CODE_W-1:0] CODE_ACT = CODE_W'(0);
   localparam logic [CODE_W-1:0] CODE_BYP = CODE_W'(1);

   amc_mode_e nxt;
   logic      sw_ok;
   amc_mode_e sw_tgt;

   assign sw_ok  = sw_valid && ((sw_code == CODE_ACT) || (sw_code == CODE_BYP));
   assign sw_tgt = (sw_code == CODE_BYP) ? MD_BYPASS : MD_ACTIVE;

   // priority outside sleep: clock loss, sleep request, switch, standby expiry
   always_comb begin
      nxt = mode_q;
      if (mode_q == MD_SLEEP) begin
         if (scl_act) nxt = MD_STANDBY;
      end else if (clk_lost || sleep_req) begin
         nxt = MD_SLEEP;
      end else if (sw_ok) begin
         nxt = sw_tgt;
      end else if ((mode_q == MD_STANDBY) && stby_exp) begin
         nxt = MD_SLEEP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= boot_bypass ? MD_BYPASS : MD_ACTIVE;
      else        mode_q <= nxt;
   end
endmodule

// File: rtl/amc_out_dec.sv
`timescale 1ns/1ps
module amc_out_dec
   import amc_pkg::*;
#(
   parameter bit REG_OUT = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  amc_mode_e mode_i,
   output amc_ctl_t  ctl_o
);
   if (REG_OUT) begin : g_reg
      amc_ctl_t ctl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ctl_q <= '0;
         else        ctl_q <= amc_decode(mode_i);
      end
      assign ctl_o = ctl_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign ctl_o = amc_decode(mode_i);
   end
endmodule

// File: rtl/audio_mode_ctrl.sv
`timescale 1ns/1ps
module audio_mode_ctrl
   import amc_pkg::*;
#(
   parameter int unsigned STBY_W  = 16,
   parameter int unsigned WIN_W   = 8,
   parameter int unsigned CODE_W  = 3,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boot_bypass,
   input  logic              sw_valid,
   input  logic [CODE_W-1:0] sw_code,
   input  logic              sleep_req,
   input  logic              scl_act,
   input  logic              ext_tick,
   input  logic [STBY_W-1:0] stby_lim,
   input  logic [WIN_W-1:0]  clk_win,
   output logic [1:0]        mode_o,
   output logic              proc_en_o,
   output logic              byp_sel_o,
   output logic              stats_en_o,
   output logic              analog_en_o,
   output logic              osc_int_o
);
   if (STBY_W < 1 || STBY_W > 32) begin : g_bad_stby
      $error("audio_mode_ctrl: STBY_W out of range 1..32");
   end
   if (WIN_W < 2 || WIN_W > 32) begin : g_bad_win
      $error("audio_mode_ctrl: WIN_W out of range 2..32");
   end
   if (CODE_W < 1 || CODE_W > 8) begin : g_bad_code
      $error("audio_mode_ctrl: CODE_W out of range 1..8");
   end

   amc_mode_e mode_q;
   logic      clk_lost;
   logic      stby_exp;
   amc_ctl_t  ctl;

   amc_clk_mon #(.WIN_W(WIN_W)) u_clk_mon (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_tick (ext_tick),
      .win      (clk_win),
      .lost     (clk_lost)
   );

   amc_stby_timer #(.STBY_W(STBY_W)) u_stby (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (mode_q == MD_STANDBY),
      .limit  (stby_lim),
      .expire (stby_exp)
   );

   amc_mode_fsm #(.CODE_W(CODE_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .boot_bypass (boot_bypass),
      .sw_valid    (sw_valid),
      .sw_code     (sw_code),
      .sleep_req   (sleep_req),
      .scl_act     (scl_act),
      .clk_lost    (clk_lost),
      .stby_exp    (stby_exp),
      .mode_q      (mode_q)
   );

   amc_out_dec #(.REG_OUT(REG_OUT)) u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (mode_q),
      .ctl_o  (ctl)
   );

   assign mode_o      = mode_q;
   assign proc_en_o   = ctl.proc_en;
   assign byp_sel_o   = ctl.byp_sel;
   assign stats_en_o  = ctl.stats_en;
   assign analog_en_o = ctl.analog_en;
   assign osc_int_o   = ctl.osc_int;
endmodule

// File: rtl/amc_chk.sv
`timescale 1ns/1ps
module amc_chk #(
   parameter int unsigned CODE_W  = 3,
   parameter bit          REG_OUT = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode,
   input logic              sw_valid,
   input logic [CODE_W-1:0] sw_code,
   input logic              sleep_req,
   input logic              scl_act,
   input logic              clk_lost,
   input logic              stby_exp,
   input logic              proc_en,
   input logic              byp_sel,
   input logic              stats_en,
   input logic              analog_en,
   input logic              osc_int
);
   localparam logic [1:0] K_ACT = 2'd0;
   localparam logic [1:0] K_BYP = 2'd1;
   localparam logic [1:0] K_SLP = 2'd2;
   localparam logic [1:0] K_STB = 2'd3;

   logic awake, quiet, code_ok;
   assign awake   = (mode != K_SLP);
   assign quiet   = !clk_lost && !sleep_req;
   assign code_ok = sw_code <= CODE_W'(1);

   p_switch_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
      awake && quiet && sw_valid && (sw_code == CODE_W'(0)) |=> mode == K_ACT);

   p_switch_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      awake && quiet && sw_valid && (sw_code == CODE_W'(1)) |=> mode == K_BYP);

   p_bad_code_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == K_ACT) || (mode == K_BYP)) && quiet && !(sw_valid && code_ok) |=> $stable(mode));

   p_sleep_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      awake && sleep_req |=> mode == K_SLP);

   p_sleep_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == K_SLP) && !scl_act |=> mode == K_SLP);

   p_sleep_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == K_SLP) && scl_act |=> mode == K_STB);

   p_stby_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == K_STB) && stby_exp && quiet && !(sw_valid && code_ok) |=> mode == K_SLP);

   p_clock_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
      awake && clk_lost |=> mode == K_SLP);

   p_route_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({proc_en, byp_sel}));

   if (REG_OUT) begin : g_reg_chk
      p_sleep_outs_r8: assert property (@(posedge clk) disable iff (!rst_n)
         mode == K_SLP |=> !proc_en && !analog_en && !stats_en && osc_int);
   end else begin : g_comb_chk
      p_sleep_outs_r8: assert property (@(posedge clk) disable iff (!rst_n)
         mode == K_SLP |-> !proc_en && !analog_en && !stats_en && osc_int);
   end
endmodule

bind audio_mode_ctrl amc_chk #(.CODE_W(CODE_W), .REG_OUT(REG_OUT)) u_amc_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode      (mode_o),
   .sw_valid  (sw_valid),
   .sw_code   (sw_code),
   .sleep_req (sleep_req),
   .scl_act   (scl_act),
   .clk_lost  (clk_lost),
   .stby_exp  (stby_exp),
   .proc_en   (proc_en_o),
   .byp_sel   (byp_sel_o),
   .stats_en  (stats_en_o),
   .analog_en (analog_en_o),
   .osc_int   (osc_int_o)
);

// File: tb/audio_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module audio_mode_ctrl_tb_top;
   localparam logic [1:0] M_A = 2'd0;
   localparam logic [1:0] M_B = 2'd1;
   localparam logic [1:0] M_S = 2'd2;
   localparam logic [1:0] M_T = 2'd3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boot_bypass = 1'b1;
   logic        sw_valid = 1'b0;
   logic [2:0]  sw_code = '0;
   logic        sleep_req = 1'b0;
   logic        scl_act = 1'b0;
   logic        ext_tick = 1'b1;
   logic [15:0] stby_lim = 16'd5;
   logic [7:0]  clk_win = 8'd6;
   logic [1:0]  mode_o;
   logic        proc_en_o, byp_sel_o, stats_en_o, analog_en_o, osc_int_o;

   int unsigned n_chk = 0;
   int unsigned n_fail = 0;
   bit          done = 1'b0;

   logic [1:0] exp_q[$];
   string      tag_q[$];

   always #4 clk = ~clk;

   audio_mode_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .boot_bypass(boot_bypass),
      .sw_valid(sw_valid), .sw_code(sw_code), .sleep_req(sleep_req),
      .scl_act(scl_act), .ext_tick(ext_tick), .stby_lim(stby_lim),
      .clk_win(clk_win), .mode_o(mode_o), .proc_en_o(proc_en_o),
      .byp_sel_o(byp_sel_o), .stats_en_o(stats_en_o),
      .analog_en_o(analog_en_o), .osc_int_o(osc_int_o)
   );

   // enable pattern per mode, from R8
   function automatic logic [4:0] want_outs(input logic [1:0] m);
      case (m)
         M_A:     return 5'b10110;
         M_B:     return 5'b01110;
         M_S:     return 5'b00001;
         default: return 5'b00010;
      endcase
   endfunction

   task automatic compare(input logic [1:0] em, input string tag);
      logic [4:0] got;
      got = {proc_en_o, byp_sel_o, stats_en_o, analog_en_o, osc_int_o};
      n_chk++;
      if (mode_o !== em) begin
         n_fail++;
         $display("FAIL %s: mode=%0d expected=%0d", tag, mode_o, em);
      end
      n_chk++;
      if (got !== want_outs(em)) begin
         n_fail++;
         $display("FAIL %s (R8 enables): got=%b expected=%b", tag, got, want_outs(em));
      end
   endtask

   // driver: one command cycle, expectation queued for the monitor
   task automatic step(input logic sv, input logic [2:0] sc, input logic sl,
                       input logic sa, input logic tk, input logic [1:0] em,
                       input string tag);
      @(negedge clk);
      sw_valid = sv; sw_code = sc; sleep_req = sl; scl_act = sa; ext_tick = tk;
      exp_q.push_back(em);
      tag_q.push_back(tag);
   endtask

   task automatic idle_pins();
      @(negedge clk);
      sw_valid = 1'b0; sw_code = '0; sleep_req = 1'b0; scl_act = 1'b0; ext_tick = 1'b1;
   endtask

   task automatic do_reset(input logic bb);
      @(negedge clk);
      rst_n = 1'b0;
      boot_bypass = bb;
      repeat (2) @(negedge clk);
      compare(bb ? M_B : M_A, "R1 during reset");
      rst_n = 1'b1;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   // monitor: samples 2 ns after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            logic [1:0] em;
            string      t;
            em = exp_q.pop_front();
            t  = tag_q.pop_front();
            compare(em, t);
         end
      end
   end

   initial begin
      #1600000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      do_reset(1'b1);
      step(0, 0, 0, 0, 1, M_B, "R1 boot bypass after release");
      step(1, 0, 0, 0, 1, M_A, "R2 bypass to active");
      step(1, 5, 0, 0, 1, M_A, "R3 code 5 ignored");
      step(1, 1, 0, 0, 1, M_B, "R2 active to bypass");
      step(1, 3, 0, 0, 1, M_B, "R3 code 3 ignored");
      step(1, 2, 0, 0, 1, M_B, "R3 code 2 ignored");
      step(1, 0, 1, 0, 1, M_S, "R4 sleep beats switch");
      step(1, 0, 0, 0, 1, M_S, "R5 switch ignored in sleep");
      step(0, 0, 1, 0, 1, M_S, "R5 sleep request ignored in sleep");
      step(0, 0, 0, 1, 1, M_T, "R5 serial clock wake to standby");
      step(0, 0, 0, 0, 1, M_T, "R6 standby waiting");
      step(1, 6, 0, 0, 1, M_T, "R3 code 6 ignored in standby");
      step(1, 0, 0, 0, 1, M_A, "R2 standby to active");
      step(0, 0, 1, 0, 1, M_S, "R4 sleep from active");
      step(0, 0, 0, 1, 1, M_T, "R5 wake");
      for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, M_T, "R6 within limit");
      step(0, 0, 0, 0, 1, M_S, "R6 timeout to sleep");
      step(0, 0, 0, 1, 1, M_T, "R5 wake again");
      for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, M_T, "R6 within limit");
      step(1, 1, 0, 0, 1, M_B, "R6 switch on expiry edge wins");
      step(0, 0, 1, 0, 1, M_S, "R4 sleep from bypass");
      step(0, 0, 0, 1, 1, M_T, "R5 wake");
      step(0, 0, 1, 0, 1, M_S, "R4 sleep from standby");
      step(0, 0, 0, 1, 1, M_T, "R5 wake");
      step(1, 0, 0, 0, 1, M_A, "R2 standby to active");
      for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, M_A, "R7 gap inside window");
      step(1, 1, 0, 0, 0, M_S, "R7 clock loss overrides switch");
      step(0, 0, 0, 1, 0, M_T, "R5 wake without clock");
      step(0, 0, 0, 0, 0, M_S, "R7 standby drops on lost clock");
      step(0, 0, 0, 1, 1, M_T, "R7 wake as clock returns");
      step(1, 0, 0, 0, 1, M_A, "R7 tick clears loss");
      idle_pins();
      idle_pins();
      do_reset(1'b0);
      step(0, 0, 0, 0, 1, M_A, "R1 boot active after release");
      idle_pins();
      idle_pins();
      done = 1'b1;
      summary();
      $finish;
   end
endmodule